// File: doc/BRIEF.md
# Asynchronous Timer Register Update Unit

This block holds an 8-bit timer/counter that advances on a slow, free-running timer clock, such as a watch-crystal domain, and lets a much faster CPU-side bus program and observe it. Software sees four byte-wide locations: the live count, the compare value, the control byte and a status byte. The status byte gathers one update-pending bit per programmable register and two sticky event flags.

A CPU write does not reach the timer directly. It lands in a CPU-side holding register for that location. A toggle bit carries the request across the clock boundary. The timer domain then commits the held value and toggles an acknowledge back, and that acknowledge clears the pending bit. Each of the three registers has its own holding register and handshake, so updates to different registers proceed in parallel. The count reads back live, while compare and control read back what was last written.

Overflow (255 to 0) and compare-equal events arise in the timer domain. They are sampled into the CPU domain, where they set sticky flags that software clears by writing ones. Correct sampling requires the CPU clock to run more than four times faster than the timer clock. Software must wait for a register's pending bit to clear before writing that register again.

Top module: `async_tmr_bridge`

## Requirements
- R1: The counter, compare and control registers each have their own holding register and handshake. Writes to two different registers on nearby cycles both set their pending bits, and both values are committed.
- R2: A written value is committed in the timer domain on the second rising edge of `tclk` after the write. The pending bit for that register is therefore still set 60 ns after the write when `tclk` has an 80 ns period.
- R3: Status bit 0 (count), bit 1 (compare) and bit 2 (control) read 1 from the cycle after a write to that register until the commit has been acknowledged, and 0 otherwise.
- R4: `rd_data` is registered and follows `bus_addr` one cycle later. Address 0 returns the running count, even before a pending count write has been committed. Address 1 returns the compare holding register. Address 2 returns the control holding register. Address 3 returns the status byte.
- R5: No compare event is raised while a write to the count or to the compare value is pending. Loading the count with the compare value while the counter runs therefore leaves the compare flag clear.
- R6: Once the pending bit for a count write has cleared, address 0 returns the written value while the counter is stopped.
- R7: The counter advances by one on each `tclk` rising edge while control bit 0 is 1, and holds its value while control bit 0 is 0. The other control bits are stored and read back but have no effect.
- R8: When the count wraps from 255 to 0, status bit 4 and the `ovf_flag` output become 1.
- R9: When the running count equals the compare value, status bit 5 and the `cmp_flag` output become 1.
- R10: Writing to address 3 with bit 4 or bit 5 set clears the matching sticky flag. Writing 0 to that bit leaves the flag set.
- R11: Reset clears the count, compare and control registers, all holding registers, all pending bits and both sticky flags. Every address then reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous active-high reset, also synchronized into the timer domain |
| tclk | input | 1 | Slow asynchronous timer clock |
| bus_addr | input | 2 | Register select: 0 count, 1 compare, 2 control, 3 status |
| bus_we | input | 1 | Write strobe for the selected register, one cycle per write |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the address of the previous cycle |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The hardest situation to bring about is a compare match that coincides with a pending update. The count must equal the compare value in exactly the `tclk` edges during which the suppression is active. The bench starts the counter from a value far from the compare value. It then loads the count with the compare value while the counter runs, so the first edge after the commit would match if nothing masked it. It then confirms that the compare flag stays clear for several `tclk` periods. Parallel updates are reached by writing compare and control on successive CPU cycles, so that both handshakes are in flight at once, before either pending bit is polled.

// File: rtl/atb_pkg.sv
package atb_pkg;
  localparam int ADDR_W = 2;
  localparam int NREG   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CNT  = 2'd0,
    RA_CMP  = 2'd1,
    RA_CTL  = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  localparam int CTL_EN_BIT = 0;
  localparam int ST_OVF_BIT = 4;
  localparam int ST_CMP_BIT = 5;
endpackage

// File: rtl/atb_sync2.sv
module atb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/atb_wr_chan.sv
module atb_wr_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tclk,
  input  logic          trst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] hold,
  output logic          busy,
  output logic          commit
);
  logic req_tgl;
  logic req_s1;
  logic req_s2;
  logic ack_sync;

  // CPU side: capture value, flip request toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      req_tgl <= 1'b0;
    end else if (we) begin
      hold    <= wdata;
      req_tgl <= ~req_tgl;
    end
  end

  // Timer side: two edges to see the request
  always_ff @(posedge tclk) begin
    if (trst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
    end
  end

  assign commit = req_s1 ^ req_s2;

  // Acknowledge back into the CPU domain
  atb_sync2 #(.W(1)) u_ack (
    .clk (clk),
    .rst (rst),
    .d   (req_s2),
    .q   (ack_sync)
  );

  assign busy = req_tgl ^ ack_sync;

  // R3: a write raises the pending indication
  a_r3_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    we |=> busy);

  // R2: one commit strobe per request
  a_r2_one_commit: assert property (@(posedge tclk) disable iff (trst)
    commit |=> !commit);
endmodule

// File: rtl/atb_tmr_core.sv
module atb_tmr_core #(
  parameter int DW = 8
) (
  input  logic          tclk,
  input  logic          trst,
  input  logic          cnt_commit,
  input  logic [DW-1:0] cnt_wdata,
  input  logic          cmp_commit,
  input  logic [DW-1:0] cmp_wdata,
  input  logic          en_commit,
  input  logic          en_wdata,
  input  logic          mask,
  output logic [DW-1:0] cnt,
  output logic          ev_ovf,
  output logic          ev_cmp
);
  localparam logic [DW-1:0] CMAX = {DW{1'b1}};

  logic [DW-1:0] cmp_r;
  logic          en_r;
  logic          hit;
  logic          wrap;

  assign hit  = (cnt == cmp_r);
  assign wrap = (cnt == CMAX);

  always_ff @(posedge tclk) begin
    if (trst) begin
      cnt    <= '0;
      cmp_r  <= '0;
      en_r   <= 1'b0;
      ev_ovf <= 1'b0;
      ev_cmp <= 1'b0;
    end else begin
      if (cnt_commit)
        cnt <= cnt_wdata;
      else if (en_r)
        cnt <= cnt + 1'b1;
      if (cmp_commit)
        cmp_r <= cmp_wdata;
      if (en_commit)
        en_r <= en_wdata;
      ev_ovf <= en_r && wrap && !cnt_commit;
      ev_cmp <= en_r && hit && !cnt_commit && !cmp_commit && !mask;
    end
  end

  // R7: stopped counter keeps its value
  a_r7_hold_when_off: assert property (@(posedge tclk) disable iff (trst)
    (!en_r && !cnt_commit) |=> $stable(cnt));

  // R8: an overflow event always coincides with a zero count
  a_r8_wrap_to_zero: assert property (@(posedge tclk) disable iff (trst)
    ev_ovf |-> (cnt == '0));
endmodule

// File: rtl/async_tmr_bridge.sv
module async_tmr_bridge
  import atb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tclk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              ovf_flag,
  output logic              cmp_flag
);
  logic [DW-1:0] hold   [NREG];
  logic [NREG-1:0] busy;
  logic [NREG-1:0] commit;
  logic [NREG-1:0] we_vec;

  logic [1:0] trst_sh;
  logic       trst;
  logic       mask_t;
  logic [DW-1:0] cnt_t;
  logic       ev_ovf_t;
  logic       ev_cmp_t;
  logic       tclk_s;
  logic       tclk_d;
  logic       t_rise;
  logic [DW-1:0] cnt_view;
  logic [DW-1:0] status;
  logic       clr_wr;

  // Reset carried into the timer domain
  always_ff @(posedge tclk) begin
    trst_sh <= {trst_sh[0], rst};
  end
  assign trst = trst_sh[1];

  // One handshake channel per register
  for (genvar i = 0; i < NREG; i++) begin : g_chan
    assign we_vec[i] = bus_we && (bus_addr == ADDR_W'(i));
    atb_wr_chan #(.DW(DW)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .tclk   (tclk),
      .trst   (trst),
      .we     (we_vec[i]),
      .wdata  (bus_wdata),
      .hold   (hold[i]),
      .busy   (busy[i]),
      .commit (commit[i])
    );
  end

  // Pending count/compare updates block compare events
  atb_sync2 #(.W(1)) u_mask (
    .clk (tclk),
    .rst (trst),
    .d   (busy[RA_CNT] | busy[RA_CMP]),
    .q   (mask_t)
  );

  atb_tmr_core #(.DW(DW)) u_core (
    .tclk       (tclk),
    .trst       (trst),
    .cnt_commit (commit[RA_CNT]),
    .cnt_wdata  (hold[RA_CNT]),
    .cmp_commit (commit[RA_CMP]),
    .cmp_wdata  (hold[RA_CMP]),
    .en_commit  (commit[RA_CTL]),
    .en_wdata   (hold[RA_CTL][CTL_EN_BIT]),
    .mask       (mask_t),
    .cnt        (cnt_t),
    .ev_ovf     (ev_ovf_t),
    .ev_cmp     (ev_cmp_t)
  );

  // Timer edge seen in CPU domain: timer state is settled here
  atb_sync2 #(.W(1)) u_tsync (
    .clk (clk),
    .rst (rst),
    .d   (tclk),
    .q   (tclk_s)
  );

  always_ff @(posedge clk) begin
    if (rst) tclk_d <= 1'b0;
    else     tclk_d <= tclk_s;
  end
  assign t_rise = tclk_s & ~tclk_d;

  assign clr_wr = bus_we && (bus_addr == RA_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_view <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (t_rise)
        cnt_view <= cnt_t;
      if (t_rise && ev_ovf_t)
        ovf_flag <= 1'b1;
      else if (clr_wr && bus_wdata[ST_OVF_BIT])
        ovf_flag <= 1'b0;
      if (t_rise && ev_cmp_t)
        cmp_flag <= 1'b1;
      else if (clr_wr && bus_wdata[ST_CMP_BIT])
        cmp_flag <= 1'b0;
    end
  end

  always_comb begin
    status             = '0;
    status[NREG-1:0]   = busy;
    status[ST_OVF_BIT] = ovf_flag;
    status[ST_CMP_BIT] = cmp_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_addr_e'(bus_addr))
        RA_CNT:  rd_data <= cnt_view;
        RA_CMP:  rd_data <= hold[RA_CMP];
        RA_CTL:  rd_data <= hold[RA_CTL];
        default: rd_data <= status;
      endcase
    end
  end

  // R10: sticky flags stay until a write-one clear
  a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(clr_wr && bus_wdata[ST_OVF_BIT])) |=> ovf_flag);

  a_r10_sticky_cmp: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !(clr_wr && bus_wdata[ST_CMP_BIT])) |=> cmp_flag);
endmodule

// File: tb/sim_async_tmr_bridge.sv
module sim_async_tmr_bridge;
  logic       clk = 1'b0;
  logic       tclk = 1'b0;
  logic       rst;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic       ovf_flag;
  logic       cmp_flag;

  int checks = 0;
  int failures = 0;

  async_tmr_bridge #(.DW(8)) u0 (
    .clk       (clk),
    .rst       (rst),
    .tclk      (tclk),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag)
  );

  always #4 clk = ~clk;
  initial begin
    #13;
    forever #40 tclk = ~tclk;
  end

  // {addr, data}; control entries keep bit 0 low
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'h5A}, {2'd1, 8'h33}, {2'd2, 8'h00}, {2'd1, 8'hFF},
    {2'd0, 8'hA5}, {2'd2, 8'hFE}, {2'd1, 8'h00}, {2'd0, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 300; k++) begin
      rd(2'd3, st);
      if (st[2:0] == 3'b000) break;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_tclk(input int n);
    repeat (n) @(posedge tclk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, v2, prev_cnt;
    logic [1:0] a;
    logic [7:0] d;
    rst = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    repeat (40) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    // R11: reset state at every address
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R11 reset read", v, 8'h00);
    end

    // Vector walk: R3, R4, R6
    prev_cnt = 8'h00;
    for (int i = 0; i < 8; i++) begin
      a = VEC[i][9:8];
      d = VEC[i][7:0];
      wr(a, d);
      rd(a, v);
      if (a == 2'd0) chk("R4 live count before commit", v, prev_cnt);
      else           chk("R4 holding readback", v, d);
      rd(2'd3, v);
      chk("R3 pending bit set", {7'b0, v[a]}, 8'h01);
      wait_idle();
      rd(2'd3, v);
      chk("R3 pending bits clear", {5'b0, v[2:0]}, 8'h00);
      if (a == 2'd0) begin
        rd(2'd0, v);
        chk("R6 committed count", v, d);
        prev_cnt = d;
      end
    end

    // R2: still pending before two timer edges can elapse
    wr(2'd1, 8'h55);
    repeat (5) @(negedge clk);
    rd(2'd3, v);
    chk("R2 pending at 60ns", {7'b0, v[1]}, 8'h01);
    wait_idle();

    // R7: counting and holding
    wr(2'd2, 8'h01); wait_idle();
    rd(2'd0, v);
    wait_tclk(20);
    rd(2'd0, v2);
    v2 = v2 - v;
    chk("R7 advance by about 20", {7'b0, (v2 >= 8'd19 && v2 <= 8'd21)}, 8'h01);
    wr(2'd2, 8'h00); wait_idle();
    wait_tclk(2);
    rd(2'd0, v);
    wait_tclk(10);
    rd(2'd0, v2);
    chk("R7 hold when disabled", v2, v);

    // R8: overflow, R10: write-one clear
    wr(2'd0, 8'hFA); wait_idle();
    wr(2'd1, 8'h80); wait_idle();
    wr(2'd3, 8'h30);
    rd(2'd3, v);
    chk("R10 flags cleared", {6'b0, v[5:4]}, 8'h00);
    wr(2'd2, 8'h01); wait_idle();
    wait_tclk(10);
    wr(2'd2, 8'h00); wait_idle();
    rd(2'd3, v);
    chk("R8 overflow status", {7'b0, v[4]}, 8'h01);
    chk("R8 ovf_flag port", {7'b0, ovf_flag}, 8'h01);
    chk("R9 no compare yet", {7'b0, v[5]}, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    chk("R10 zero write keeps flag", {7'b0, v[4]}, 8'h01);
    wr(2'd3, 8'h10);
    rd(2'd3, v);
    chk("R10 write-one clears", {7'b0, v[4]}, 8'h00);
    chk("R10 ovf_flag port cleared", {7'b0, ovf_flag}, 8'h00);

    // R9: compare match
    wr(2'd0, 8'h00); wait_idle();
    wr(2'd1, 8'h1E); wait_idle();
    wait_tclk(3);
    wr(2'd3, 8'h30);
    wr(2'd2, 8'h01); wait_idle();
    wait_tclk(18);
    rd(2'd3, v);
    chk("R9 before reaching compare", {7'b0, v[5]}, 8'h00);
    wait_tclk(17);
    rd(2'd3, v);
    chk("R9 compare status", {7'b0, v[5]}, 8'h01);
    chk("R9 cmp_flag port", {7'b0, cmp_flag}, 8'h01);
    wr(2'd2, 8'h00); wait_idle();

    // R5: loading count with compare value while running
    wr(2'd0, 8'h90); wait_idle();
    wr(2'd1, 8'h40); wait_idle();
    wr(2'd2, 8'h01); wait_idle();
    wait_tclk(3);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h40); wait_idle();
    wait_tclk(5);
    rd(2'd3, v);
    chk("R5 suppressed compare", {7'b0, v[5]}, 8'h00);
    wr(2'd2, 8'h00); wait_idle();

    // R1: parallel compare and control updates
    wr(2'd0, 8'h08); wait_idle();
    wait_tclk(3);
    wr(2'd3, 8'h30);
    wr(2'd1, 8'h11);
    wr(2'd2, 8'h01);
    rd(2'd3, v);
    chk("R1 both pending", {6'b0, v[2:1]}, 8'h03);
    wait_idle();
    rd(2'd1, v);
    chk("R1 compare holding", v, 8'h11);
    rd(2'd2, v);
    chk("R1 control holding", v, 8'h01);
    wait_tclk(20);
    rd(2'd3, v);
    chk("R1 compare committed alongside control", {7'b0, v[5]}, 8'h01);

    // R11: reset while running with flags set
    wr(2'd1, 8'h77);
    wait_idle();
    rst = 1'b1;
    repeat (40) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R11 reset mid-run", v, 8'h00);
    end
    chk("R11 flag ports", {6'b0, ovf_flag, cmp_flag}, 8'h00);
    wait_tclk(5);
    rd(2'd0, v);
    chk("R11 counter stopped after reset", v, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule